// File: doc/BRIEF.md
# Arithmetic Shift Unit with Condition Flags

This block shifts either one 16-bit register value or a 32-bit register pair by an amount and direction that both come from a single signed 6-bit count field. Right shifts are arithmetic, so the sign bit is replicated into the vacated top positions. Left shifts feed zeros in at the bottom. The shifter moves one bit per clock. A `start` pulse launches an operation, and a one-cycle `done` pulse presents the result together with the updated negative, zero, overflow and carry flags and the write enables for the two registers of the pair.

In single mode the shifted value is the `hi_word` operand, which is the selected register, and only the even write enable fires. In combined mode `hi_word` is the even register and forms the upper half. `lo_word` is the odd register and forms the lower half. Both halves are written back the same way. The caller reads the operands and writes the results. The caller also supplies the flag value that the carry keeps when no shift takes place.

Top module: `ashu_top`

## Requirements
- R1: When the count field `shift_op[5:0]` is zero, the result equals the operand, V is 0, C equals `carry_in`, and N and Z reflect the operand. `done` is high one clock after the start is accepted.
- R2: When `shift_op[5]` is 1, the operand shifts right by 64 minus the 6-bit field value, so the range is 1 to 32. Every step copies the original sign bit into the MSB.
- R3: When `shift_op[5]` is 0 and the field is nonzero, the operand shifts left by `shift_op[4:0]`, with zeros entering at the LSB.
- R4: After a nonzero shift, C is the last bit shifted out. For a right shift that is the bit leaving the LSB of the operand width, and for a left shift it is the bit leaving the MSB.
- R5: N equals the result MSB (`res_hi[15]`). Z is 1 exactly when the whole result is zero: the 16-bit word in single mode, all 32 bits in combined mode.
- R6: V is 1 exactly when the MSB of the result differs from the MSB of the original operand.
- R7: With `combined` = 1, the operand is `{hi_word, lo_word}` and the result returns as `{res_hi, res_lo}`. With `combined` = 0, only `hi_word` is shifted, and `res_lo` reads zero.
- R8: `wr_even` is high only while `done` is high. `wr_odd` is high only when `done` is high in combined mode.
- R9: A start accepted at a clock edge gives `done` after shift-amount + 1 edges, counting that edge. `busy` is high on every cycle in between, and `done` lasts exactly one cycle.
- R10: A `start` raised while an operation is running or finishing is ignored and does not disturb the result in progress.
- R11: Bits 15:6 of `shift_op` have no effect on any output.
- R12: While reset is asserted and right after it is released, `busy`, `done`, `wr_even` and `wr_odd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken only when idle |
| combined | input | 1 | 1 selects the 32-bit register pair, 0 selects a single 16-bit register |
| hi_word | input | 16 | Selected register, or even register of the pair |
| lo_word | input | 16 | Odd register of the pair |
| shift_op | input | 16 | Shift operand; only the low 6 bits count |
| carry_in | input | 1 | Present carry flag, kept when no shift occurs |
| busy | output | 1 | Shift in progress |
| done | output | 1 | One-cycle result strobe |
| res_hi | output | 16 | Result for the selected or even register |
| res_lo | output | 16 | Result for the odd register (combined mode) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow (sign change) flag |
| flag_c | output | 1 | Carry flag |
| wr_even | output | 1 | Write enable for the even or selected register |
| wr_odd | output | 1 | Write enable for the odd register |

## Verification
The bench counts falling edges from the edge that accepts `start`. It expects `done` at exactly shift-amount + 1, so 1 for a zero count and up to 33 for a 32-place right shift. Result words, flags and write enables are sampled only at that falling edge. `busy` and the quiet write enables are checked one falling edge after the start. The bench waits one more edge after `done` so that the next start lands in the idle state. In the overlap case a second `start` is driven during the run, and the original result is still expected on the original schedule.

// File: rtl/ashu_pkg.sv
package ashu_pkg;
  typedef enum logic [1:0] {
    ASH_IDLE = 2'd0,
    ASH_RUN  = 2'd1,
    ASH_DONE = 2'd2
  } ash_state_e;
endpackage

// File: rtl/ashu_decode.sv
// Splits the signed count field into a direction and a step count.
module ashu_decode #(
  parameter int FIELD_W = 6
) (
  input  logic [FIELD_W-1:0] field,
  output logic               go_right,
  output logic               no_shift,
  output logic [FIELD_W-1:0] amount
);
  localparam logic [FIELD_W:0] SPAN = (FIELD_W+1)'(1) << FIELD_W;

  logic [FIELD_W:0] neg_mag;

  always_comb begin
    go_right = field[FIELD_W-1];
    no_shift = (field == '0);
    neg_mag  = SPAN - {1'b0, field};
    if (go_right) amount = neg_mag[FIELD_W-1:0];
    else          amount = {1'b0, field[FIELD_W-2:0]};
  end
endmodule

// File: rtl/ashu_datapath.sv
// Double-width accumulator that moves one bit per enabled step.
module ashu_datapath #(
  parameter int WORD_W = 16,
  localparam int ACC_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              combined,
  input  logic              go_right,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  input  logic              carry_in,
  output logic [ACC_W-1:0]  acc,
  output logic              carry,
  output logic              orig_sign,
  output logic              comb_mode
);
  logic [ACC_W-1:0] acc_d;
  logic             carry_d, sign_d, comb_d, right_q, right_d;
  logic             reg_en;

  always_comb begin
    acc_d   = acc;
    carry_d = carry;
    sign_d  = orig_sign;
    comb_d  = comb_mode;
    right_d = right_q;
    reg_en  = load | step;
    if (load) begin
      acc_d   = {hi_word, (combined ? lo_word : {WORD_W{1'b0}})};
      carry_d = carry_in;
      sign_d  = hi_word[WORD_W-1];
      comb_d  = combined;
      right_d = go_right;
    end else if (step) begin
      if (right_q) begin
        carry_d = comb_mode ? acc[0] : acc[WORD_W];
        acc_d   = {acc[ACC_W-1], acc[ACC_W-1:1]};
      end else begin
        carry_d = acc[ACC_W-1];
        acc_d   = {acc[ACC_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      carry     <= 1'b0;
      orig_sign <= 1'b0;
      comb_mode <= 1'b0;
      right_q   <= 1'b0;
    end else if (reg_en) begin
      acc       <= acc_d;
      carry     <= carry_d;
      orig_sign <= sign_d;
      comb_mode <= comb_d;
      right_q   <= right_d;
    end
  end
endmodule

// File: rtl/ashu_flags.sv
// Result split and condition flags from the accumulator.
module ashu_flags #(
  parameter int WORD_W = 16,
  localparam int ACC_W = 2 * WORD_W
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic              comb_mode,
  input  logic              orig_sign,
  input  logic              carry,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);
  always_comb begin
    res_hi = acc[ACC_W-1:WORD_W];
    res_lo = comb_mode ? acc[WORD_W-1:0] : {WORD_W{1'b0}};
    flag_n = acc[ACC_W-1];
    flag_z = (res_hi == '0) && (res_lo == '0);
    flag_v = flag_n ^ orig_sign;
    flag_c = carry;
  end
endmodule

// File: rtl/ashu_top.sv
module ashu_top #(
  parameter int WORD_W  = 16,
  parameter int FIELD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              combined,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] shift_op,
  input  logic              carry_in,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              wr_even,
  output logic              wr_odd
);
  import ashu_pkg::*;
  localparam int ACC_W = 2 * WORD_W;

  ash_state_e         state_q, state_d;
  logic [FIELD_W-1:0] cnt_q, cnt_d;
  logic               go_right, no_shift, accept, step;
  logic [FIELD_W-1:0] amount;
  logic [ACC_W-1:0]   acc;
  logic               carry, orig_sign, comb_mode;
  logic               unused_op_bits;

  assign unused_op_bits = ^shift_op[WORD_W-1:FIELD_W];

  ashu_decode #(.FIELD_W(FIELD_W)) u_dec (
    .field(shift_op[FIELD_W-1:0]), .go_right(go_right),
    .no_shift(no_shift), .amount(amount)
  );

  assign accept = start && (state_q == ASH_IDLE);
  assign step   = (state_q == ASH_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ASH_IDLE: if (start) begin
        cnt_d   = amount;
        state_d = no_shift ? ASH_DONE : ASH_RUN;
      end
      ASH_RUN: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == FIELD_W'(1)) state_d = ASH_DONE;
      end
      ASH_DONE: state_d = ASH_IDLE;
      default:  state_d = ASH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ASH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  ashu_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .combined(combined), .go_right(go_right), .hi_word(hi_word),
    .lo_word(lo_word), .carry_in(carry_in), .acc(acc), .carry(carry),
    .orig_sign(orig_sign), .comb_mode(comb_mode)
  );

  ashu_flags #(.WORD_W(WORD_W)) u_flg (
    .acc(acc), .comb_mode(comb_mode), .orig_sign(orig_sign), .carry(carry),
    .res_hi(res_hi), .res_lo(res_lo), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
  );

  assign busy    = (state_q == ASH_RUN);
  assign done    = (state_q == ASH_DONE);
  assign wr_even = done;
  assign wr_odd  = done && comb_mode;
endmodule

// File: rtl/ashu_chk.sv
module ashu_chk #(
  parameter int WORD_W  = 16,
  parameter int FIELD_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              combined,
  input logic [WORD_W-1:0] hi_word,
  input logic [WORD_W-1:0] shift_op,
  input logic              carry_in,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] res_hi,
  input logic [WORD_W-1:0] res_lo,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c,
  input logic              wr_even,
  input logic              wr_odd
);
  logic accepted, sign_cap, mode_cap;
  assign accepted = start && !busy && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_cap <= 1'b0;
      mode_cap <= 1'b0;
    end else if (accepted) begin
      sign_cap <= hi_word[WORD_W-1];
      mode_cap <= combined;
    end
  end

  assert_noshift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && shift_op[FIELD_W-1:0] == '0) |=>
      (done && flag_c == $past(carry_in) && res_hi == $past(hi_word)));

  assert_n_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_n == res_hi[WORD_W-1]));

  assert_z_whole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == ((res_hi == '0) && (!mode_cap || res_lo == '0))));

  assert_v_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_v == (sign_cap ^ res_hi[WORD_W-1])));

  assert_wr_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_even || wr_odd) |-> done);

  assert_wr_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_even && (wr_odd == mode_cap)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_run_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> (busy || done));

  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind ashu_top ashu_chk #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .combined(combined),
  .hi_word(hi_word), .shift_op(shift_op), .carry_in(carry_in), .busy(busy),
  .done(done), .res_hi(res_hi), .res_lo(res_lo), .flag_n(flag_n),
  .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .wr_even(wr_even),
  .wr_odd(wr_odd)
);

// File: tb/ashu_top_test.sv
`timescale 1ns/1ps
module ashu_top_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, combined, carry_in;
  logic [15:0] hi_word, lo_word, shift_op;
  logic busy, done, flag_n, flag_z, flag_v, flag_c, wr_even, wr_odd;
  logic [15:0] res_hi, res_lo;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  ashu_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .combined(combined),
    .hi_word(hi_word), .lo_word(lo_word), .shift_op(shift_op),
    .carry_in(carry_in), .busy(busy), .done(done), .res_hi(res_hi),
    .res_lo(res_lo), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .wr_even(wr_even), .wr_odd(wr_odd)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic comb, input logic [15:0] hi,
      input logic [15:0] lo, input logic [15:0] op, input logic cin,
      output logic [31:0] res, output logic n, output logic z,
      output logic v, output logic c, output int amt);
    int w;
    logic [31:0] x, msk;
    logic s;
    logic [5:0] f;
    f   = op[5:0];
    w   = comb ? 32 : 16;
    x   = comb ? {hi, lo} : {16'h0, hi};
    msk = comb ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    s   = x[w-1];
    c   = cin;
    if (f == 6'd0)  amt = 0;
    else if (f[5])  amt = 64 - int'(f);
    else            amt = int'(f[4:0]);
    for (int i = 0; i < amt; i++) begin
      if (f[5]) begin
        c = x[0];
        x = (x >> 1) | ({31'b0, s} << (w - 1));
      end else begin
        c = x[w-1];
        x = (x << 1) & msk;
      end
    end
    res = x;
    n   = x[w-1];
    z   = (x == 32'd0);
    v   = n ^ s;
  endfunction

  task automatic run_op(input logic comb, input logic [15:0] hi,
      input logic [15:0] lo, input logic [15:0] op, input logic cin,
      input bit poke, input string name);
    logic [31:0] er;
    logic en, ez, ev, ec;
    int amt, lat;
    string tag;
    model(comb, hi, lo, op, cin, er, en, ez, ev, ec, amt);
    if (name != "")           tag = name;
    else if (op[5:0] == 6'd0) tag = "R1";
    else if (comb)            tag = "R7";
    else if (op[5])           tag = "R2";
    else                      tag = "R3";
    @(negedge clk);
    start = 1'b1; combined = comb; hi_word = hi; lo_word = lo;
    shift_op = op; carry_in = cin;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (amt > 0) begin
      chk("R9", "busy during shift", {31'b0, busy}, 32'd1);
      chk("R8", "write enables before done", {30'b0, wr_even, wr_odd}, 32'd0);
    end
    while (!done && lat < 40) begin
      if (poke && lat == 1) begin
        start = 1'b1; hi_word = ~hi; shift_op = 16'h0001; combined = ~comb;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk("R9", "latency", lat, amt + 1);
    chk(tag, "res_hi", {16'b0, res_hi}, comb ? {16'b0, er[31:16]} : {16'b0, er[15:0]});
    chk("R7", "res_lo", {16'b0, res_lo}, comb ? {16'b0, er[15:0]} : 32'd0);
    chk(op[5:0] == 6'd0 ? "R1" : "R4", "carry", {31'b0, flag_c}, {31'b0, ec});
    chk("R5", "negative", {31'b0, flag_n}, {31'b0, en});
    chk("R5", "zero", {31'b0, flag_z}, {31'b0, ez});
    chk("R6", "overflow", {31'b0, flag_v}, {31'b0, ev});
    chk("R8", "write enables at done", {30'b0, wr_even, wr_odd}, {30'b0, 1'b1, comb});
    @(negedge clk);
    chk("R9", "done single cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd12345));
    rst_n = 1'b0; start = 1'b0; combined = 1'b0; carry_in = 1'b0;
    hi_word = '0; lo_word = '0; shift_op = '0;
    repeat (3) @(negedge clk);
    chk("R12", "outputs in reset", {28'b0, busy, done, wr_even, wr_odd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "outputs after reset", {28'b0, busy, done, wr_even, wr_odd}, 32'd0);

    run_op(1'b0, 16'h1234, 16'h0, 16'h0000, 1'b1, 1'b0, "R1");
    run_op(1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, "R1");
    run_op(1'b0, 16'h8001, 16'h0, 16'h003F, 1'b0, 1'b0, "R2");
    run_op(1'b0, 16'h8000, 16'h0, 16'h0020, 1'b0, 1'b0, "R2");
    run_op(1'b1, 16'h8000, 16'h0001, 16'h0020, 1'b0, 1'b0, "R2");
    run_op(1'b1, 16'h4000, 16'hFFFF, 16'h0020, 1'b1, 1'b0, "R2");
    run_op(1'b0, 16'h8000, 16'h0, 16'h0001, 1'b0, 1'b0, "R6");
    run_op(1'b0, 16'h4001, 16'h0, 16'h001F, 1'b0, 1'b0, "R3");
    run_op(1'b1, 16'h0000, 16'h0001, 16'h001F, 1'b0, 1'b0, "R3");
    run_op(1'b1, 16'h0001, 16'h8000, 16'h0001, 1'b0, 1'b0, "R7");
    run_op(1'b0, 16'h00F0, 16'h0, 16'hFFC4, 1'b0, 1'b0, "R11");
    run_op(1'b1, 16'hA5A5, 16'h5A5A, 16'h7F3D, 1'b1, 1'b0, "R11");
    run_op(1'b0, 16'hC3C3, 16'h0, 16'h0035, 1'b0, 1'b1, "R10");
    run_op(1'b1, 16'h1357, 16'h9BDF, 16'h000A, 1'b1, 1'b1, "R10");

    for (int k = 0; k < 400; k++) begin
      run_op(1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
             1'($urandom), 1'($urandom_range(0, 7) == 0), "");
    end
    finish_run();
  end
endmodule